// File: doc/BRIEF.md
# Multi-Mode PRG Bank Mapper

This block turns a CPU address in the 0x6000–0xFFFF range into a physical program ROM address. Four bank registers hold the inner bank numbers. A mode byte picks how the window is cut up: two 16 KB halves or four 8 KB slots. A second control byte supplies a two-bit outer bank that is merged above the inner bank, so a large ROM can be split into blocks.

In one 8 KB mode the 0x6000–0x7FFF window can also be mapped. That window then takes register 3, and the top slot at 0xE000 is pinned to the last inner bank. The translation is combinational from the current address, the control bytes and the register contents. Register writes arrive on the CPU bus at 0x8000–0x8003 and take effect on the next clock edge.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset every bank register reads as 0xFF. In mode 3, address 0xE000 then maps to 8 KB bank {outer, 0x3F}, which is the last inner bank.
- R2: When cpu_wr_i is high at a clock edge with cpu_addr_i = 0x8000+n (n = 0..3), register n takes cpu_data_i. Writes to any other address, and bus cycles without cpu_wr_i, leave all four registers unchanged.
- R3: Modes 0 and 1 (ctrl_mode_i[1:0]) select 16 KB mapping. 0x8000–0xBFFF uses register 0 and 0xC000–0xFFFF uses register 2. The 16 KB bank is (reg & 0x1F) | (outer << 4). prg_addr_o = {1'b0, bank16[5:0], cpu_addr_i[13:0]}.
- R4: Modes 2 and 3 select 8 KB mapping. Slot k = cpu_addr_i[14:13] (0x8000, 0xA000, 0xC000, 0xE000 in that order) uses register k. The 8 KB bank is (reg & 0x3F) | (outer << 6). prg_addr_o = {bank8[7:0], cpu_addr_i[12:0]}.
- R5: In mode 2 with ctrl_mode_i[7] set, 0x6000–0x7FFF is valid and mapped through register 3 as in R4. The slot at 0xE000 is forced to inner bank 0x3F.
- R6: The outer bank is ctrl_outer_i[2:1]. In 8 KB modes it appears unchanged in prg_addr_o[20:19].
- R7: prg_valid_o is low for addresses below 0x6000, and also for 0x6000–0x7FFF unless R5 applies. It is high for every address at or above 0x8000. While prg_valid_o is low, prg_addr_o is zero.
- R8: ctrl_mode_i bits 6:2 and ctrl_outer_i bits 7:3 and 0 have no effect on the outputs.
- R9: In mode 3, ctrl_mode_i[7] has no effect: 0x6000–0x7FFF stays unmapped and 0xE000 uses register 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address for translation and for register writes |
| cpu_wr_i | input | 1 | Write strobe for the bank registers |
| cpu_data_i | input | 8 | Write data |
| ctrl_mode_i | input | 8 | Mode byte: [1:0] banking mode, [7] enable the 0x6000 window |
| ctrl_outer_i | input | 8 | Outer bank byte: [2:1] outer bank |
| prg_addr_o | output | 21 | Physical program ROM byte address |
| prg_valid_o | output | 1 | Address falls in a mapped window |

## Verification
The assertions assume that cpu_addr_i and both control bytes carry known values after reset. The hold property assumes the outputs move only when the address, a control byte or a register write changes. The bench therefore drives all inputs once per cycle, on the falling edge. It raises cpu_wr_i only inside its write task, so a translation sample never overlaps a register update. Random control bytes carry random values in their ignored bits, so the 8 KB, 16 KB and window cases are all reached with irrelevant bits toggling.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  typedef enum logic [1:0] {
    MAP_16K_A = 2'd0,
    MAP_16K_B = 2'd1,
    MAP_8K_WIN = 2'd2,
    MAP_8K = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic       hit;
    logic       use_16k;
    logic [1:0] reg_sel;
    logic       force_last;
  } win_sel_t;
endpackage

// File: rtl/prg_bank_regs.sv
module prg_bank_regs #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '1;  // last bank after reset
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        regs_o[g] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int CPU_ADDR_W = 16
) (
  input  logic [CPU_ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]            mode_i,
  input  logic                  win_en_i,
  output win_sel_t              sel_o
);
  map_mode_e mode;
  logic      low_win_on;
  logic [2:0] top3;

  assign mode       = map_mode_e'(mode_i);
  assign low_win_on = win_en_i && (mode == MAP_8K_WIN);
  assign top3       = cpu_addr_i[CPU_ADDR_W-1 -: 3];

  always_comb begin
    sel_o = '0;
    if (top3[2]) begin
      sel_o.hit     = 1'b1;
      sel_o.use_16k = (mode == MAP_16K_A) || (mode == MAP_16K_B);
      if (sel_o.use_16k) begin
        sel_o.reg_sel = {top3[1], 1'b0};
      end else begin
        sel_o.reg_sel    = top3[1:0];
        sel_o.force_last = low_win_on && (top3[1:0] == 2'b11);
      end
    end else if (top3 == 3'b011 && low_win_on) begin
      sel_o.hit     = 1'b1;
      sel_o.reg_sel = 2'b11;
    end
  end
endmodule

// File: rtl/prg_bank_compose.sv
module prg_bank_compose
  import prg_map_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int DATA_W     = 8,
  parameter int CPU_ADDR_W = 16,
  parameter int INNER8_W   = 6,
  parameter int INNER16_W  = 5,
  parameter int OUTER_W    = 2,
  localparam int PAGE8_W   = CPU_ADDR_W - 3,
  localparam int PAGE16_W  = CPU_ADDR_W - 2,
  localparam int BANK8_W   = OUTER_W + INNER8_W,
  localparam int BANK16_W  = OUTER_W + INNER16_W - 1,
  localparam int PRG_W     = BANK8_W + PAGE8_W
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  win_sel_t                        sel_i,
  input  logic [OUTER_W-1:0]              outer_i,
  input  logic [CPU_ADDR_W-1:0]           cpu_addr_i,
  output logic [PRG_W-1:0]                prg_addr_o,
  output logic                            prg_valid_o
);
  logic [DATA_W-1:0]        reg_val;
  logic [INNER8_W-1:0]      inner8;
  logic [BANK8_W-1:0]       bank8;
  logic [BANK16_W-1:0]      bank16;
  logic [BANK16_W+PAGE16_W-1:0] addr16;

  assign reg_val = regs_i[sel_i.reg_sel];
  assign inner8  = sel_i.force_last ? '1 : reg_val[INNER8_W-1:0];
  assign bank8   = {outer_i, inner8};
  // outer overlaps the top inner bit in 16 KB mode; merged by OR
  assign bank16  = (BANK16_W'(outer_i) << (INNER16_W - 1))
                 | BANK16_W'(reg_val[INNER16_W-1:0]);
  assign addr16  = {bank16, cpu_addr_i[PAGE16_W-1:0]};

  always_comb begin
    prg_valid_o = sel_i.hit;
    if (!sel_i.hit)          prg_addr_o = '0;
    else if (sel_i.use_16k)  prg_addr_o = PRG_W'(addr16);
    else                     prg_addr_o = {bank8, cpu_addr_i[PAGE8_W-1:0]};
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int CPU_ADDR_W = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 4,
  parameter int INNER8_W   = 6,
  parameter int INNER16_W  = 5,
  parameter int OUTER_W    = 2,
  parameter int OUTER_LSB  = 1,
  parameter int WIN_EN_BIT = 7,
  parameter logic [CPU_ADDR_W-1:0] REG_BASE = 16'h8000,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int PRG_W     = OUTER_W + INNER8_W + CPU_ADDR_W - 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [CPU_ADDR_W-1:0] cpu_addr_i,
  input  logic                  cpu_wr_i,
  input  logic [DATA_W-1:0]     cpu_data_i,
  input  logic [DATA_W-1:0]     ctrl_mode_i,
  input  logic [DATA_W-1:0]     ctrl_outer_i,
  output logic [PRG_W-1:0]      prg_addr_o,
  output logic                  prg_valid_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic                            reg_wr;
  win_sel_t                        sel;

  assign reg_wr = cpu_wr_i
               && (cpu_addr_i[CPU_ADDR_W-1:IDX_W] == REG_BASE[CPU_ADDR_W-1:IDX_W]);

  prg_bank_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (reg_wr),
    .wr_idx_i  (cpu_addr_i[IDX_W-1:0]),
    .wr_data_i (cpu_data_i),
    .regs_o    (regs)
  );

  prg_window_decode #(.CPU_ADDR_W(CPU_ADDR_W)) u_dec (
    .cpu_addr_i (cpu_addr_i),
    .mode_i     (ctrl_mode_i[1:0]),
    .win_en_i   (ctrl_mode_i[WIN_EN_BIT]),
    .sel_o      (sel)
  );

  prg_bank_compose #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .CPU_ADDR_W(CPU_ADDR_W),
    .INNER8_W(INNER8_W), .INNER16_W(INNER16_W), .OUTER_W(OUTER_W)
  ) u_comp (
    .regs_i      (regs),
    .sel_i       (sel),
    .outer_i     (ctrl_outer_i[OUTER_LSB +: OUTER_W]),
    .cpu_addr_i  (cpu_addr_i),
    .prg_addr_o  (prg_addr_o),
    .prg_valid_o (prg_valid_o)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_wr_i,
  input logic [7:0]  ctrl_mode_i,
  input logic [7:0]  ctrl_outer_i,
  input logic [20:0] prg_addr_o,
  input logic        prg_valid_o
);
  logic started;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started <= 1'b0;
    else         started <= 1'b1;
  end

  AST_LOW_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i < 16'h6000) |-> !prg_valid_o); // R7
  AST_HIGH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_addr_i[15] |-> prg_valid_o); // R7
  AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prg_valid_o |-> (prg_addr_o == '0)); // R7
  AST_WINDOW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b011 && !(ctrl_mode_i[7] && ctrl_mode_i[1:0] == 2'd2))
    |-> !prg_valid_o); // R9
  AST_LAST_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_mode_i[7] && ctrl_mode_i[1:0] == 2'd2 && cpu_addr_i[15:13] == 3'b111)
    |-> (prg_addr_o[18:13] == 6'h3F)); // R5
  AST_OUTER_8K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prg_valid_o && ctrl_mode_i[1]) |-> (prg_addr_o[20:19] == ctrl_outer_i[2:1])); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started && !$past(cpu_wr_i) && $stable(cpu_addr_i) && $stable(ctrl_mode_i)
     && $stable(ctrl_outer_i)) |-> $stable(prg_addr_o)); // R2
endmodule

bind prg_bank_mapper prg_bank_mapper_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_wr_i     (cpu_wr_i),
  .ctrl_mode_i  (ctrl_mode_i),
  .ctrl_outer_i (ctrl_outer_i),
  .prg_addr_o   (prg_addr_o),
  .prg_valid_o  (prg_valid_o)
);

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic [7:0]  cpu_data_i = '0;
  logic [7:0]  ctrl_mode_i = 8'h03;
  logic [7:0]  ctrl_outer_i = '0;
  logic [20:0] prg_addr_o;
  logic        prg_valid_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] sh [4];

  always #5 clk_i = ~clk_i;

  prg_bank_mapper dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_wr_i(cpu_wr_i),
    .cpu_data_i(cpu_data_i), .ctrl_mode_i(ctrl_mode_i), .ctrl_outer_i(ctrl_outer_i),
    .prg_addr_o(prg_addr_o), .prg_valid_o(prg_valid_o)
  );

  function automatic logic [21:0] model(input logic [15:0] a, input logic [7:0] c0,
                                        input logic [7:0] c3);
    logic [1:0] outer = c3[2:1];
    logic [1:0] mode = c0[1:0];
    logic win = c0[7] && (mode == 2'd2);
    logic [7:0] r;
    logic [5:0] b16;
    logic [5:0] inner;
    if (a < 16'h6000) return '0;
    if (a < 16'h8000) begin
      if (!win) return '0;
      return {1'b1, outer, sh[3][5:0], a[12:0]};
    end
    if (mode < 2'd2) begin
      r = a[14] ? sh[2] : sh[0];
      b16 = {1'b0, r[4:0]} | ({4'b0, outer} << 4);
      return {1'b1, 1'b0, b16, a[13:0]};
    end
    r = sh[a[14:13]];
    inner = (win && a[14:13] == 2'b11) ? 6'h3F : r[5:0];
    return {1'b1, outer, inner, a[12:0]};
  endfunction

  function automatic string classify(input logic [15:0] a, input logic [7:0] c0);
    if (a < 16'h6000) return "R7";
    if (a < 16'h8000) return (c0[7] && c0[1:0] == 2'd2) ? "R5" : "R7";
    if (c0[1:0] < 2'd2) return "R3";
    if (c0[7] && c0[1:0] == 2'd2 && a[14:13] == 2'b11) return "R5";
    return "R4";
  endfunction

  task automatic check(input string tag, input logic [21:0] exp);
    logic [21:0] got = {prg_valid_o, prg_addr_o};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h mode=%h outer=%h got=%h exp=%h", tag, cpu_addr_i,
               ctrl_mode_i, ctrl_outer_i, got, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] a, input logic [7:0] c0, input logic [7:0] c3,
                        input string tag);
    @(negedge clk_i);
    cpu_addr_i = a; ctrl_mode_i = c0; ctrl_outer_i = c3; cpu_wr_i = 1'b0;
    #1;
    check(tag, model(a, c0, c3));
  endtask

  task automatic write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_data_i = d; cpu_wr_i = 1'b1;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    if (a[15:2] == 14'h2000) sh[a[1:0]] = d;
  endtask

  task automatic verify_regs(input string tag);
    for (int k = 0; k < 4; k++) lookup(16'h8000 + 16'(k) * 16'h2000 + 16'h0011, 8'h03, 8'h00, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) sh[k] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    lookup(16'hE000, 8'h03, 8'h06, "R1");
    lookup(16'hFFFF, 8'h03, 8'h00, "R1");
    verify_regs("R1");
    // R2 register loads
    write(16'h8000, 8'h05); write(16'h8001, 8'h2A);
    write(16'h8002, 8'h13); write(16'h8003, 8'hFC);
    verify_regs("R2");
    // R2 writes elsewhere are ignored
    write(16'h8004, 8'h00); write(16'h7FFF, 8'h00); write(16'hA000, 8'h00);
    write(16'h9003, 8'h00); write(16'h0000, 8'h00);
    verify_regs("R2");
    // R3 16 KB mode, outer overlap on bit 4
    lookup(16'h8123, 8'h00, 8'h04, "R3");
    lookup(16'hC456, 8'h01, 8'h04, "R3");
    lookup(16'hA000, 8'h01, 8'h02, "R3");
    lookup(16'hFFFF, 8'h00, 8'h06, "R3");
    // R4 each 8 KB slot
    for (int k = 0; k < 4; k++) lookup(16'h8000 + 16'(k) * 16'h2000 + 16'h0ABC, 8'h02, 8'h02, "R4");
    // R5 low window and pinned top slot
    lookup(16'h6ABC, 8'h82, 8'h06, "R5");
    lookup(16'h7FFF, 8'h82, 8'h00, "R5");
    lookup(16'hE001, 8'h82, 8'h02, "R5");
    lookup(16'hC001, 8'h82, 8'h02, "R5");
    // R6 outer sweep
    for (int o = 0; o < 4; o++) lookup(16'hA222, 8'h03, 8'(o << 1), "R6");
    // R7 invalid regions
    lookup(16'h7000, 8'h02, 8'h06, "R7");
    lookup(16'h5FFF, 8'h82, 8'h06, "R7");
    lookup(16'h0000, 8'h82, 8'h00, "R7");
    lookup(16'h6000, 8'h80, 8'h00, "R7");
    // R8 ignored bits
    lookup(16'hE555, 8'h7F, 8'hF9, "R8");
    lookup(16'h6555, 8'hFE, 8'hF8, "R8");
    lookup(16'h9555, 8'h7C, 8'hFF, "R8");
    // R9 mode 3 ignores the window enable
    lookup(16'h6123, 8'h83, 8'h02, "R9");
    lookup(16'hE123, 8'h83, 8'h02, "R9");
    // random mix
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 4) == 0) begin
        logic [15:0] wa = (($urandom % 5) == 0) ? 16'($urandom) : 16'h8000 + 16'($urandom % 8);
        write(wa, 8'($urandom));
      end else begin
        logic [15:0] a = 16'($urandom);
        logic [7:0] c0 = 8'($urandom);
        lookup(a, c0, 8'($urandom), classify(a, c0));
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule